// File: doc/BRIEF.md
# Scanline Sprite Selector

This block decides, once per video line, which hardware sprites will be drawn on the line about to be displayed. A line-start strobe supplies the line number. The block then walks a 32-entry attribute table in video memory through a simple read request/response port. It compares each entry's vertical position against the line and keeps up to four intersecting sprites, in table order. For each kept sprite it presents the pattern row to fetch, the horizontal position with early-clock correction, the pattern number and the colour. A one-cycle done strobe tells the pixel pipeline that the slot outputs are final.

The block also maintains the overflow part of a status register. This part is a sticky flag raised by the first sprite that exceeds the four-per-line limit, together with a five-bit sprite number. When no overflow is pending, the number reports the last entry that was examined. A status-read pulse clears the flag. Evaluation is suppressed in the 40-column text mode and while the display is blanked.

Top module: `spr_line_eval`

## Requirements
- R1: Entry n of the table is read at byte address {cfg_attr_base, n[4:0], k[1:0]}. Field k=0 is Y, k=1 is X, k=2 is pattern, k=3 is colour. Each request is a single-cycle rd_req pulse, and the next request waits for rd_valid.
- R2: An entry whose Y byte equals 208 ends the scan. That entry and all later entries contribute no slot and cannot overflow.
- R3: A sprite with Y=v covers lines (v+1) mod 256 onward. Its pattern row offset is d=(line-v-1) mod 256, so Y=255 starts on line 0 and Y=254 shows only from its second row.
- R4: Sprite height H is 8, or 16 when cfg_size16 is set, and is doubled when cfg_mag is set. A sprite intersects when d<H. The row offset output is d, or d>>1 when cfg_mag is set.
- R5: At most four intersecting sprites are kept, in slots 0..3 in table order, and slot_cnt reports how many. Slots at or above slot_cnt read as all zero.
- R6: The fifth intersecting entry sets fifth_flag and loads its index into fifth_num, if the flag was clear. Sprites with colour 0 or an off-screen X still count toward the limit.
- R7: With no overflow on a line and the flag clear, fifth_num takes the last index examined at done. This is 31 when no terminator was met, otherwise the terminator's index.
- R8: Once set, fifth_flag and fifth_num hold through later lines, including lines that overflow again, until a status_read pulse clears the flag.
- R9: The slot X output is the 9-bit two's-complement value X-32 when colour bit 7 (early clock) is set, and X otherwise. The colour output is colour bits 3..0. The pattern output is the pattern byte with bits 1..0 cleared when cfg_size16 is set.
- R10: When cfg_text_mode is set or cfg_show is clear, a line-start raises done on the next cycle. In that case slot_cnt is 0, no read is issued, and fifth_flag and fifth_num are unchanged.
- R11: done is a one-cycle pulse issued once per accepted line-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Starts evaluation for line_num |
| line_num | input | 8 | Line to be evaluated |
| cfg_size16 | input | 1 | 16x16 sprites when set, 8x8 when clear |
| cfg_mag | input | 1 | Doubles sprite pixels |
| cfg_show | input | 1 | Display enable; evaluation off when clear |
| cfg_text_mode | input | 1 | Text mode; evaluation off when set |
| cfg_attr_base | input | 7 | Attribute table base, address bits 13..7 |
| rd_req | output | 1 | Memory read request pulse |
| rd_addr | output | 14 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| status_read | input | 1 | Status read pulse; clears fifth_flag |
| done | output | 1 | Evaluation complete pulse |
| slot_cnt | output | 3 | Number of kept sprites |
| slot_row | output | 16 | Row offset, 4 bits per slot |
| slot_x | output | 36 | Adjusted X, 9 signed bits per slot |
| slot_pat | output | 32 | Pattern number, 8 bits per slot |
| slot_col | output | 16 | Colour, 4 bits per slot |
| fifth_flag | output | 1 | Overflow flag |
| fifth_num | output | 5 | Overflow index or last examined index |

## Verification
A wrong entry index or field counter shows up at the very next done. The wrong bytes appear in a slot, the slot count is wrong, or fifth_num names an index other than the terminator, 31 or the true first excess entry. A flag or number that fails to hold appears on the first later line whose result differs, so the bench sweeps every line of a small table under all size and magnify settings. It interleaves status reads so that both the hold path and the reload path are seen. A wrong wrap in the line arithmetic appears only on lines 0 and 1 with Y near 255, and those lines are part of every sweep.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

  typedef struct packed {
    logic [3:0] row;
    logic [8:0] xpos;
    logic [7:0] pat;
    logic [3:0] col;
  } slot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} ev_state_t;

  // horizontal position after optional 32-pixel left shift, 9-bit two's complement
  function automatic logic [8:0] early_adjust(input logic [7:0] x, input logic ec);
    return {1'b0, x} - {3'b000, ec, 5'b00000};
  endfunction

endpackage

// File: rtl/spr_hit_calc.sv
module spr_hit_calc #(
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] ypos,
  input  logic              size16,
  input  logic              mag,
  output logic              hit,
  output logic [3:0]        row
);
  logic [LINE_W-1:0] delta;
  logic [5:0]        height;

  always_comb begin
    delta  = line - ypos - LINE_W'(1);
    height = size16 ? 6'd16 : 6'd8;
    if (mag) height = height << 1;
    hit = ({{(LINE_W-6){1'b0}}, height} > delta);
    row = mag ? delta[4:1] : delta[3:0];
  end
endmodule

// File: rtl/spr_slot_bank.sv
module spr_slot_bank
  import spr_eval_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int SEL_W = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  slot_t              wr_data,
  output logic [4*NSLOT-1:0] row_o,
  output logic [9*NSLOT-1:0] x_o,
  output logic [8*NSLOT-1:0] pat_o,
  output logic [4*NSLOT-1:0] col_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    slot_t q;
    always_ff @(posedge clk) begin
      if (rst || clear) q <= '0;
      else if (wr_en && wr_sel == SEL_W'(g)) q <= wr_data;
    end
    assign row_o[g*4 +: 4] = q.row;
    assign x_o[g*9 +: 9]   = q.xpos;
    assign pat_o[g*8 +: 8] = q.pat;
    assign col_o[g*4 +: 4] = q.col;
  end

  assert_no_clear_write_R5: assert property (@(posedge clk) disable iff (rst)
    !(clear && wr_en));
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
  import spr_eval_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int NENT   = 32,
  parameter int LINE_W = 8,
  parameter int ADDR_W = 14,
  parameter int TERM_Y = 208,
  localparam int IDX_W  = $clog2(NENT),
  localparam int BASE_W = ADDR_W - IDX_W - 2,
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int SEL_W  = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic [LINE_W-1:0]  line_num,
  input  logic               cfg_size16,
  input  logic               cfg_mag,
  input  logic               cfg_show,
  input  logic               cfg_text_mode,
  input  logic [BASE_W-1:0]  cfg_attr_base,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_valid,
  input  logic [7:0]         rd_data,
  input  logic               status_read,
  output logic               done,
  output logic [CNT_W-1:0]   slot_cnt,
  output logic [4*NSLOT-1:0] slot_row,
  output logic [9*NSLOT-1:0] slot_x,
  output logic [8*NSLOT-1:0] slot_pat,
  output logic [4*NSLOT-1:0] slot_col,
  output logic               fifth_flag,
  output logic [IDX_W-1:0]   fifth_num
);
  ev_state_t         st;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [1:0]        fsel;
  logic [CNT_W-1:0]  cnt;
  logic [LINE_W-1:0] line_q;
  logic [3:0]        row_q;
  logic [7:0]        x_q, pat_q;
  logic              ovf_q, req_q, done_q, flag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  fnum_q;

  logic       hit;
  logic [3:0] hit_row;
  logic       enabled, bank_clear, bank_wr, at_end;
  slot_t      new_slot;

  spr_hit_calc #(.LINE_W(LINE_W)) u_hit (
    .line(line_q), .ypos(rd_data), .size16(cfg_size16), .mag(cfg_mag),
    .hit(hit), .row(hit_row)
  );

  always_comb begin
    enabled     = cfg_show && !cfg_text_mode;
    bank_clear  = (st == ST_IDLE) && line_start;
    bank_wr     = (st == ST_WAIT) && rd_valid && (fsel == 2'd3);
    at_end      = (idx == IDX_W'(NENT - 1));
    new_slot.row  = row_q;
    new_slot.xpos = early_adjust(x_q, rd_data[7]);
    new_slot.pat  = cfg_size16 ? {pat_q[7:2], 2'b00} : pat_q;
    new_slot.col  = rd_data[3:0];
  end

  spr_slot_bank #(.NSLOT(NSLOT)) u_bank (
    .clk(clk), .rst(rst), .clear(bank_clear), .wr_en(bank_wr),
    .wr_sel(cnt[SEL_W-1:0]), .wr_data(new_slot),
    .row_o(slot_row), .x_o(slot_x), .pat_o(slot_pat), .col_o(slot_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; idx <= '0; last_idx <= '0; fsel <= '0; cnt <= '0;
      line_q <= '0; row_q <= '0; x_q <= '0; pat_q <= '0; ovf_q <= 1'b0;
      req_q <= 1'b0; done_q <= 1'b0; flag_q <= 1'b0; addr_q <= '0; fnum_q <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      if (status_read) flag_q <= 1'b0;
      case (st)
        ST_IDLE: if (line_start) begin
          line_q <= line_num; idx <= '0; fsel <= '0; cnt <= '0; ovf_q <= 1'b0;
          if (enabled) st <= ST_ISSUE;
          else done_q <= 1'b1;
        end
        ST_ISSUE: begin
          req_q  <= 1'b1;
          addr_q <= {cfg_attr_base, idx, fsel};
          st     <= ST_WAIT;
        end
        ST_WAIT: if (rd_valid) begin
          case (fsel)
            2'd0: begin
              if (rd_data == 8'(TERM_Y)) begin
                last_idx <= idx; st <= ST_FIN;
              end else if (hit && cnt == CNT_W'(NSLOT)) begin
                ovf_q <= 1'b1; st <= ST_FIN;
                if (!flag_q) begin flag_q <= 1'b1; fnum_q <= idx; end
              end else if (hit) begin
                row_q <= hit_row; fsel <= 2'd1; st <= ST_ISSUE;
              end else if (at_end) begin
                last_idx <= idx; st <= ST_FIN;
              end else begin
                idx <= idx + 1'b1; st <= ST_ISSUE;
              end
            end
            2'd1: begin x_q <= rd_data; fsel <= 2'd2; st <= ST_ISSUE; end
            2'd2: begin pat_q <= rd_data; fsel <= 2'd3; st <= ST_ISSUE; end
            default: begin
              cnt  <= cnt + 1'b1;
              fsel <= 2'd0;
              if (at_end) begin last_idx <= idx; st <= ST_FIN; end
              else begin idx <= idx + 1'b1; st <= ST_ISSUE; end
            end
          endcase
        end
        default: begin
          done_q <= 1'b1;
          if (!flag_q && !ovf_q) fnum_q <= last_idx;
          st <= ST_IDLE;
        end
      endcase
    end
  end

  assign rd_req     = req_q;
  assign rd_addr    = addr_q;
  assign done       = done_q;
  assign slot_cnt   = cnt;
  assign fifth_flag = flag_q;
  assign fifth_num  = fnum_q;

  assert_single_req_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  assert_req_in_table_R1: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[ADDR_W-1 -: BASE_W] == cfg_attr_base);
  assert_slot_limit_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(NSLOT));
  assert_sticky_fifth_R8: assert property (@(posedge clk) disable iff (rst)
    (fifth_flag && !status_read) |=> (fifth_flag && $stable(fifth_num)));
  assert_disabled_quick_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && line_start && !enabled) |=> (done && !rd_req && $stable(fifth_num)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_spr_line_eval.sv
module sim_spr_line_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic [7:0]  line_num = '0;
  logic        cfg_size16 = 1'b0, cfg_mag = 1'b0, cfg_show = 1'b1, cfg_text_mode = 1'b0;
  logic [6:0]  cfg_attr_base = 7'h35;
  logic        rd_req, rd_valid = 1'b0;
  logic [13:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        status_read = 1'b0;
  logic        done;
  logic [2:0]  slot_cnt;
  logic [15:0] slot_row, slot_col;
  logic [35:0] slot_x;
  logic [31:0] slot_pat;
  logic        fifth_flag;
  logic [4:0]  fifth_num;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_line_eval u0 (
    .clk(clk), .rst(rst), .line_start(line_start), .line_num(line_num),
    .cfg_size16(cfg_size16), .cfg_mag(cfg_mag), .cfg_show(cfg_show),
    .cfg_text_mode(cfg_text_mode), .cfg_attr_base(cfg_attr_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .status_read(status_read), .done(done), .slot_cnt(slot_cnt),
    .slot_row(slot_row), .slot_x(slot_x), .slot_pat(slot_pat), .slot_col(slot_col),
    .fifth_flag(fifth_flag), .fifth_num(fifth_num)
  );

  logic [7:0] mem [0:127];
  int base_err = 0;
  int rd_total = 0;
  always @(posedge clk) begin
    rd_valid <= rd_req;
    rd_data  <= mem[rd_addr[6:0]];
    if (rd_req) begin
      rd_total <= rd_total + 1;
      if (rd_addr[13:7] != cfg_attr_base) base_err <= base_err + 1;
    end
  end

  int errors = 0, checks = 0;
  bit m_flag = 0;
  int m_num = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic status_pulse();
    @(negedge clk); status_read = 1'b1;
    @(negedge clk); status_read = 1'b0;
    m_flag = 0;
    chk(fifth_flag == 1'b0, "R8 flag cleared by status read", int'(fifth_flag), 0);
  endtask

  // returns number of cycles from strobe to done
  task automatic strobe(input int ln, output int waited);
    @(negedge clk); line_num = 8'(ln); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    waited = 1;
    while (!done && waited < 3000) begin @(negedge clk); waited++; end
  endtask

  task automatic eval_line(input int ln);
    int e_cnt, e_row[4], e_x[4], e_pat[4], e_col[4], last, oidx, w, be;
    bit ovf, stop;
    e_cnt = 0; ovf = 0; stop = 0; last = 31; oidx = 0;
    for (int s = 0; s < 4; s++) begin e_row[s]=0; e_x[s]=0; e_pat[s]=0; e_col[s]=0; end
    for (int i = 0; i < 32 && !stop; i++) begin
      int y, d, h;
      y = mem[i*4];
      if (y == 208) begin last = i; stop = 1; end
      else begin
        d = (ln - y - 1) & 255;
        h = (cfg_size16 ? 16 : 8) * (cfg_mag ? 2 : 1);
        if (d < h) begin
          if (e_cnt == 4) begin ovf = 1; oidx = i; stop = 1; end
          else begin
            e_row[e_cnt] = cfg_mag ? d / 2 : d;
            e_x[e_cnt]   = mem[i*4+1] - (mem[i*4+3][7] ? 32 : 0);
            e_pat[e_cnt] = cfg_size16 ? (mem[i*4+2] & 8'hFC) : mem[i*4+2];
            e_col[e_cnt] = mem[i*4+3] & 15;
            e_cnt++;
          end
        end
      end
    end
    if (ovf) begin if (!m_flag) begin m_flag = 1; m_num = oidx; end end
    else if (!m_flag) m_num = last;
    be = base_err;
    strobe(ln, w);
    chk(done == 1'b1, "R11 done reached", int'(done), 1);
    chk(base_err == be, "R1 read address base", base_err - be, 0);
    chk(int'(slot_cnt) == e_cnt, "R5 slot count", int'(slot_cnt), e_cnt);
    for (int s = 0; s < 4; s++) begin
      int ax;
      ax = $signed(slot_x[s*9 +: 9]);
      chk(int'(slot_row[s*4 +: 4]) == e_row[s], "R3 R4 row offset", int'(slot_row[s*4 +: 4]), e_row[s]);
      chk(ax == e_x[s], "R9 adjusted X", ax, e_x[s]);
      chk(int'(slot_pat[s*8 +: 8]) == e_pat[s], "R9 pattern", int'(slot_pat[s*8 +: 8]), e_pat[s]);
      chk(int'(slot_col[s*4 +: 4]) == e_col[s], "R9 R5 colour", int'(slot_col[s*4 +: 4]), e_col[s]);
    end
    chk(fifth_flag == m_flag, "R6 fifth flag", int'(fifth_flag), int'(m_flag));
    chk(int'(fifth_num) == m_num, "R7 R8 fifth number", int'(fifth_num), m_num);
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", int'(done), 0);
  endtask

  task automatic fill_small();
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 11 + 1);
    // 0: wrap at 255; 1: wrap at 254; 2..6 same Y to overflow; 7 terminator (R2)
    mem[0] = 8'd255; mem[4] = 8'd254;
    for (int i = 2; i <= 6; i++) mem[i*4] = 8'd40;
    mem[3] = 8'h00;      // transparent still counts (R6)
    mem[11] = 8'h85;     // early clock
    mem[28] = 8'd208;
    mem[32] = 8'd45;     // beyond terminator, must never appear
  endtask

  task automatic fill_full();
    for (int i = 0; i < 32; i++) begin
      mem[i*4]   = 8'((i * 13 + 5) % 200);
      mem[i*4+1] = 8'((i * 37) % 256);
      mem[i*4+2] = 8'(i * 5 + 3);
      mem[i*4+3] = {i[0], 3'b010, 4'(i)};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w, rt;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && rd_req == 0, "R11 reset idle", int'(done), 0);
    chk(fifth_flag == 0 && fifth_num == 0, "R6 reset status", int'(fifth_num), 0);
    chk(slot_cnt == 0, "R5 reset count", int'(slot_cnt), 0);

    // small table, all size/magnify settings, lines wrapping through 0
    fill_small();
    for (int c = 0; c < 4; c++) begin
      cfg_size16 = c[0]; cfg_mag = c[1];
      for (int ln = 0; ln < 64; ln++) begin
        eval_line(ln);
        if (ln % 7 == 3) status_pulse();
      end
    end

    // full table without terminator, last index 31 (R7)
    fill_full();
    status_pulse();
    for (int c = 0; c < 2; c++) begin
      cfg_size16 = c[0]; cfg_mag = c[0];
      for (int ln = 0; ln < 192; ln++) begin
        eval_line(ln);
        if (ln % 11 == 5) status_pulse();
      end
    end

    // terminator at entry 0 (R2, R7)
    mem[0] = 8'd208;
    status_pulse();
    eval_line(10);
    chk(fifth_num == 0, "R2 terminator at 0", int'(fifth_num), 0);

    // disabled evaluation (R10)
    fill_small();
    cfg_size16 = 0; cfg_mag = 0;
    eval_line(41);   // overflow sets flag to 6
    for (int k = 0; k < 2; k++) begin
      cfg_text_mode = (k == 0); cfg_show = (k != 0) ? 1'b0 : 1'b1;
      rt = rd_total;
      strobe(41, w);
      chk(w == 1, "R10 done next cycle", w, 1);
      chk(slot_cnt == 0, "R10 no slots", int'(slot_cnt), 0);
      chk(fifth_flag == m_flag && int'(fifth_num) == m_num, "R10 status unchanged",
          int'(fifth_num), m_num);
      @(negedge clk);
      chk(rd_total == rt, "R10 no reads", rd_total - rt, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule